// File: doc/BRIEF.md
# Two-Stage Cascaded Interrupt Arbiter

This block joins two eight-line interrupt controllers, a primary and a secondary, into one sixteen-line request system for a processor. Request lines 0 to 7 belong to the primary stage. Lines 8 to 15 belong to the secondary stage: bit 3 of the line number selects the stage, and bits 2:0 give the local line. Whenever the secondary stage has a line that is allowed to win, that line shows up as a pending request on line 2 of the primary stage. The processor therefore sees one interrupt output.

When the processor acknowledges, the block does three things in the same cycle. It marks the winning line in service in the stage or stages it belongs to. It captures the resolved line number on `ack_line`. It returns an 8-bit vector, which is the owning stage's 5-bit base followed by the 3-bit local line. A separate status-read strobe resolves the winner in the same way, but it clears that winner instead of marking it in service, and it reports the line number. After that strobe, the primary-stage register view shows the in-service bits.

Inside each stage the priority is fixed: the lower the line index, the higher the priority. A pending line wins only if no line of equal or higher priority is in service. Each clock cycle accepts one command. If several strobes are high together, `inta` is taken first, then `poll_rd`, then the remaining commands. `eoi_wr` and `view_irr` are then handled together.

Top module: `cascade_irq_arbiter`

## Requirements
- R1: While reset is held and right after it, `cpu_int`, `vector`, `ack_line`, `poll_data` and `mst_view` are all zero.
- R2: A line becomes pending on the clock after its input goes from 0 to 1. A line that stays high does not request again after it has been acknowledged and its service ended.
- R3: A line whose `irq_mask` bit is 1 cannot win. Clearing the mask bit lets a line that is still pending raise `cpu_int`.
- R4: A winning secondary line sets pending bit 2 of the primary stage one cycle later. The input `irq_in[2]` has no effect.
- R5: `cpu_int` is high exactly when the primary stage has an unmasked pending line whose index is lower than every in-service index of that stage. Priority is fixed, with index 0 the highest.
- R6: Acknowledging a primary line other than 2 gives `vector = {mst_base, line}` and `ack_line = line`. It also clears that line's pending bit and sets its in-service bit in the primary stage.
- R7: Acknowledging through primary line 2 gives `vector = {slv_base, local}` and `ack_line = 8 + local`. The secondary local line and primary line 2 both move from pending to in service.
- R8: An acknowledge with no winner gives `vector = {mst_base, 3'd7}` and `ack_line = 7`, and it changes no state.
- R9: `eoi_wr` clears the lowest-index in-service bit of the stage that `eoi_slave` selects (1 selects the secondary stage).
- R10: `poll_rd` resolves the primary winner and clears both its pending and its in-service bits. If that winner is line 2, the secondary winner is cleared in the same way. `poll_data` reports bit 7 = 1 with bits 3:0 holding the line number (0 to 15). It reports 0 when there is no winner, and also when primary line 2 wins but no secondary line does.
- R11: After `poll_rd`, `mst_view` shows the primary in-service bits. After `view_irr`, it shows the primary pending bits. After reset, it shows the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16 | Request lines, edge detected |
| irq_mask | input | 16 | Per-line mask, 1 blocks the line |
| mst_base | input | 5 | Upper vector bits for the primary stage |
| slv_base | input | 5 | Upper vector bits for the secondary stage |
| inta | input | 1 | Processor acknowledge strobe |
| poll_rd | input | 1 | Status-read (poll) strobe |
| eoi_wr | input | 1 | End-of-service command strobe |
| eoi_slave | input | 1 | Stage selected by eoi_wr |
| view_irr | input | 1 | Switch the register view to the pending bits |
| cpu_int | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector from the last acknowledge |
| ack_line | output | 4 | Line number captured at the last acknowledge |
| poll_data | output | 8 | Result of the last status read |
| mst_view | output | 8 | Primary in-service or pending bits |

## Verification
The hardest case to reach from the ports is this one: a secondary line outranks a secondary line already in service, but primary line 2 is itself in service, so `cpu_int` must stay low until a primary end-of-service command. The stimulus acknowledges secondary line 14, raises line 10, checks that no interrupt appears, then ends primary service and expects vector slot 2 of the secondary base. A second nesting run interleaves a primary line 0 inside an active secondary acknowledge. That run shows line 4 blocked behind the in-service cascade bit until both stages are released.

// File: rtl/cascade_irq_arbiter.sv
module cascade_irq_arbiter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic [15:0] irq_mask,
  input  logic [4:0]  mst_base,
  input  logic [4:0]  slv_base,
  input  logic        inta,
  input  logic        poll_rd,
  input  logic        eoi_wr,
  input  logic        eoi_slave,
  input  logic        view_irr,
  output logic        cpu_int,
  output logic [7:0]  vector,
  output logic [3:0]  ack_line,
  output logic [7:0]  poll_data,
  output logic [7:0]  mst_view
);

  logic [15:0] irq_q;
  logic [7:0]  m_irr, m_isr, s_irr, s_isr;
  logic [7:0]  m_irr_n, m_isr_n, s_irr_n, s_isr_n;
  logic [7:0]  vec_n, pd_n;
  logic [3:0]  al_n;
  logic        rdsel, rdsel_n;
  logic [3:0]  m_res, s_res;
  logic [15:0] rise;
  logic [7:0]  m_set, s_set;

  // {valid, line}: lowest pending index that beats every in-service index
  function automatic logic [3:0] resolve(input logic [7:0] req, input logic [7:0] svc);
    logic [3:0] r, s;
    r = 4'd8;
    s = 4'd8;
    for (int i = 7; i >= 0; i--) begin
      if (req[i]) r = 4'(i);
      if (svc[i]) s = 4'(i);
    end
    return (r < s) ? {1'b1, r[2:0]} : 4'b0;
  endfunction

  assign m_res    = resolve(m_irr & ~irq_mask[7:0], m_isr);
  assign s_res    = resolve(s_irr & ~irq_mask[15:8], s_isr);
  assign cpu_int  = m_res[3];
  assign mst_view = rdsel ? m_isr : m_irr;
  assign rise     = irq_in & ~irq_q;
  assign m_set    = {rise[7:3], s_res[3], rise[1:0]};
  assign s_set    = rise[15:8];

  always_comb begin
    m_irr_n = m_irr | m_set;
    s_irr_n = s_irr | s_set;
    m_isr_n = m_isr;
    s_isr_n = s_isr;
    vec_n   = vector;
    al_n    = ack_line;
    pd_n    = poll_data;
    rdsel_n = rdsel;
    if (inta) begin
      if (!m_res[3]) begin
        vec_n = {mst_base, 3'd7};
        al_n  = 4'd7;
      end else if (m_res[2:0] != 3'd2) begin
        m_irr_n[m_res[2:0]] = 1'b0;
        m_isr_n[m_res[2:0]] = 1'b1;
        vec_n = {mst_base, m_res[2:0]};
        al_n  = {1'b0, m_res[2:0]};
      end else begin
        m_irr_n[2] = 1'b0;
        m_isr_n[2] = 1'b1;
        if (s_res[3]) begin
          s_irr_n[s_res[2:0]] = 1'b0;
          s_isr_n[s_res[2:0]] = 1'b1;
          vec_n = {slv_base, s_res[2:0]};
          al_n  = {1'b1, s_res[2:0]};
        end else begin
          vec_n = {slv_base, 3'd7};
          al_n  = 4'hF;
        end
      end
    end else if (poll_rd) begin
      rdsel_n = 1'b1;
      pd_n    = 8'h00;
      if (m_res[3]) begin
        m_irr_n[m_res[2:0]] = 1'b0;
        m_isr_n[m_res[2:0]] = 1'b0;
        if (m_res[2:0] != 3'd2) begin
          pd_n = {1'b1, 4'b0, m_res[2:0]};
        end else if (s_res[3]) begin
          s_irr_n[s_res[2:0]] = 1'b0;
          s_isr_n[s_res[2:0]] = 1'b0;
          pd_n = {1'b1, 4'b0001, s_res[2:0]};
        end
      end
    end else begin
      if (eoi_wr) begin
        if (eoi_slave) s_isr_n = s_isr & (s_isr - 8'd1);
        else           m_isr_n = m_isr & (m_isr - 8'd1);
      end
      if (view_irr) rdsel_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= '0;
      m_irr     <= '0;
      m_isr     <= '0;
      s_irr     <= '0;
      s_isr     <= '0;
      vector    <= '0;
      ack_line  <= '0;
      poll_data <= '0;
      rdsel     <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      m_irr     <= m_irr_n;
      m_isr     <= m_isr_n;
      s_irr     <= s_irr_n;
      s_isr     <= s_isr_n;
      vector    <= vec_n;
      ack_line  <= al_n;
      poll_data <= pd_n;
      rdsel     <= rdsel_n;
    end
  end

  a_r4_cascade_from_slave: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_irr[2]) |-> $past(s_res[3]));

  a_r5_int_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> |(m_irr & ~irq_mask[7:0]));

  a_r6_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && m_res[3] && m_res[2:0] != 3'd2) |=>
      (!ack_line[3] && vector[7:3] == $past(mst_base) && m_isr[ack_line[2:0]]));

  a_r7_slave_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && m_res == 4'b1010 && s_res[3]) |=>
      (ack_line[3] && m_isr[2] && s_isr[ack_line[2:0]] && vector[7:3] == $past(slv_base)));

  a_r8_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !cpu_int) |=> (ack_line == 4'd7 && $stable(m_isr) && $stable(s_isr)));

  a_r11_poll_selects_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !inta) |=> (mst_view == m_isr));

endmodule

// File: tb/cascade_irq_arbiter_bench.sv
module cascade_irq_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] irq_in = '0, irq_mask = '0;
  logic [4:0] mst_base = 5'h04, slv_base = 5'h0E;
  logic inta = 0, poll_rd = 0, eoi_wr = 0, eoi_slave = 0, view_irr = 0;
  logic cpu_int;
  logic [7:0] vector, poll_data, mst_view;
  logic [3:0] ack_line;

  int checks = 0, failures = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  cascade_irq_arbiter u_cascade_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_mask(irq_mask),
    .mst_base(mst_base), .slv_base(slv_base), .inta(inta), .poll_rd(poll_rd),
    .eoi_wr(eoi_wr), .eoi_slave(eoi_slave), .view_irr(view_irr),
    .cpu_int(cpu_int), .vector(vector), .ack_line(ack_line),
    .poll_data(poll_data), .mst_view(mst_view));

  // behavioural reference state
  bit [7:0] mp, mi, sp, si;
  bit [15:0] prev;
  bit rv;
  bit [7:0] e_vec, e_pd;
  bit [3:0] e_al;

  function automatic int win(bit [7:0] req, bit [7:0] svc);
    for (int i = 0; i < 8; i++) begin
      if (svc[i]) return -1;
      if (req[i]) return i;
    end
    return -1;
  endfunction

  function automatic bit [7:0] drop_low(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) begin v[i] = 1'b0; return v; end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp = 0; mi = 0; sp = 0; si = 0; prev = 0; rv = 0; e_vec = 0; e_pd = 0; e_al = 0;
    end else begin
      int ms, ss;
      bit [7:0] mset, sset, mclr, sclr;
      ms = win(mp & ~irq_mask[7:0], mi);
      ss = win(sp & ~irq_mask[15:8], si);
      mset = irq_in[7:0] & ~prev[7:0];
      mset[2] = (ss >= 0);
      sset = irq_in[15:8] & ~prev[15:8];
      prev = irq_in;
      mclr = 0; sclr = 0;
      if (inta) begin
        if (ms < 0) begin e_vec = {mst_base, 3'd7}; e_al = 7; end
        else if (ms != 2) begin
          mclr[ms] = 1; mi[ms] = 1; e_vec = {mst_base, 3'(ms)}; e_al = 4'(ms);
        end else begin
          mclr[2] = 1; mi[2] = 1;
          if (ss >= 0) begin sclr[ss] = 1; si[ss] = 1; e_vec = {slv_base, 3'(ss)}; e_al = 4'(8 + ss); end
          else begin e_vec = {slv_base, 3'd7}; e_al = 15; end
        end
      end else if (poll_rd) begin
        rv = 1; e_pd = 0;
        if (ms >= 0) begin
          mclr[ms] = 1; mi[ms] = 0;
          if (ms != 2) e_pd = 8'h80 + 8'(ms);
          else if (ss >= 0) begin sclr[ss] = 1; si[ss] = 0; e_pd = 8'h88 + 8'(ss); end
        end
      end else begin
        if (eoi_wr) begin
          if (eoi_slave) si = drop_low(si); else mi = drop_low(mi);
        end
        if (view_irr) rv = 0;
      end
      mp = (mp | mset) & ~mclr;
      sp = (sp | sset) & ~sclr;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      chk({phase, " cpu_int"}, cpu_int, int'(win(mp & ~irq_mask[7:0], mi) >= 0));
      chk({phase, " vector"}, vector, e_vec);
      chk({phase, " ack_line"}, ack_line, e_al);
      chk({phase, " poll_data"}, poll_data, e_pd);
      chk({phase, " mst_view"}, mst_view, rv ? mi : mp);
    end
  endtask

  task automatic pulse_ack();   inta = 1; tick(1); inta = 0; tick(1); endtask
  task automatic pulse_poll();  poll_rd = 1; tick(1); poll_rd = 0; tick(1); endtask
  task automatic pulse_eoi(bit slv); eoi_wr = 1; eoi_slave = slv; tick(1); eoi_wr = 0; tick(1); endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset vector", vector, 0);
    chk("R1 reset cpu_int", cpu_int, 0);
    rst_n = 1; tick(2);

    phase = "R2";
    irq_in[5] = 1; tick(3);
    chk("R2 int raised", cpu_int, 1);
    pulse_ack();
    chk("R6 vector line5", vector, 8'h25);
    chk("R6 ack_line", ack_line, 5);
    pulse_eoi(0); tick(3);
    chk("R2 held line no rerequest", cpu_int, 0);
    irq_in = 0; tick(2);

    phase = "R3";
    irq_mask[3] = 1; irq_in[3] = 1; tick(4);
    chk("R3 masked no int", cpu_int, 0);
    irq_mask[3] = 0; tick(1);
    chk("R3 unmask int", cpu_int, 1);
    pulse_ack(); pulse_eoi(0); irq_in = 0; tick(2);

    phase = "R4";
    irq_in[2] = 1; tick(4);
    chk("R4 line2 input ignored", cpu_int, 0);
    chk("R4 view clear", mst_view, 0);
    irq_in[12] = 1; tick(3);
    chk("R4 cascade pending", mst_view[2], 1);
    phase = "R7";
    pulse_ack();
    chk("R7 slave vector", vector, 8'h74);
    chk("R7 slave ack_line", ack_line, 12);
    phase = "R9";
    pulse_eoi(1); pulse_eoi(0); irq_in = 0; tick(2);

    phase = "R5";
    irq_in[9] = 1; tick(3); pulse_ack();
    chk("R5 slave1 vector", vector, 8'h71);
    irq_in[0] = 1; tick(2);
    chk("R5 line0 preempts", cpu_int, 1);
    pulse_ack();
    chk("R5 line0 vector", vector, 8'h20);
    irq_in[4] = 1; tick(3);
    chk("R5 line4 blocked", cpu_int, 0);
    pulse_eoi(0); tick(1);
    chk("R9 still blocked by cascade", cpu_int, 0);
    pulse_eoi(1); pulse_eoi(0); tick(1);
    chk("R9 line4 released", cpu_int, 1);
    pulse_ack();
    chk("R6 line4 vector", vector, 8'h24);
    pulse_eoi(0); irq_in = 0; tick(2);

    irq_in[14] = 1; tick(3); pulse_ack();
    chk("R7 line14 vector", vector, 8'h76);
    irq_in[10] = 1; tick(4);
    chk("R5 cascade in service blocks", cpu_int, 0);
    pulse_eoi(0); tick(2);
    chk("R5 nested slave int", cpu_int, 1);
    pulse_ack();
    chk("R7 line10 vector", vector, 8'h72);
    chk("R7 line10 ack_line", ack_line, 10);
    pulse_eoi(1); pulse_eoi(1); pulse_eoi(0); irq_in = 0; tick(2);

    irq_in[3] = 1; irq_in[1] = 1; tick(3); pulse_ack();
    chk("R5 priority line1 first", ack_line, 1);
    pulse_eoi(0); pulse_ack();
    chk("R5 then line3", ack_line, 3);
    pulse_eoi(0); irq_in = 0; tick(2);

    phase = "R8";
    pulse_ack();
    chk("R8 spurious vector", vector, 8'h27);
    chk("R8 spurious ack_line", ack_line, 7);

    phase = "R10";
    irq_in[11] = 1; tick(3); pulse_poll();
    chk("R10 poll slave", poll_data, 8'h8B);
    chk("R10 poll cleared", cpu_int, 0);
    phase = "R11";
    chk("R11 view isr", mst_view, 0);
    view_irr = 1; tick(1); view_irr = 0; tick(1);
    irq_in = 0; tick(2);
    phase = "R10";
    irq_in[6] = 1; tick(3);
    chk("R11 view irr", mst_view, 8'h40);
    pulse_poll();
    chk("R10 poll master", poll_data, 8'h86);
    pulse_poll();
    chk("R10 poll none", poll_data, 0);
    irq_in = 0; tick(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule